// File: doc/BRIEF.md
# Dual-Path Loop Mode Controller

This block sequences the feedback paths of a hybrid frequency synthesizer that has two phase loops. One is a divider-based sampling loop, which is robust during frequency acquisition. The other is a divider-less sub-sampling loop, which gives low noise once the loop is settled. The controller starts on the sampling loop and waits for a stable lock indication. It then passes control to the sub-sampling loop and turns the sampling loop off. While the sub-sampling loop runs, it wakes an auxiliary frequency loop for a short window once every period. That auxiliary loop carries the dead-zone detector.

A sub-sampling loop can settle on the wrong harmonic of the reference. The dead-zone detector reports this by raising its out-of-range flag. When the flag is seen on enough consecutive checks, the controller goes back to acquisition on the sampling loop. Every switch between the two loops passes through one reference cycle in which both loops are disabled. All enables and the mode code are registered and change on the same clock edge as the internal state.

Top module: `loop_mode_ctrl`

## Requirements
- R1: While `rst` is high, at every clock edge, `mode_o` becomes 0 (reset mode) and `samp_en`, `subs_en` and `fll_en` become low.
- R2: On the first clock edge after `rst` falls, the block enters acquisition (`mode_o` = 1). In that mode `samp_en` is high and `subs_en` is low.
- R3: In acquisition, lock is qualified on the edge that samples `lock_in` high for the LOCK_CYCLES-th consecutive time. Any edge that samples `lock_in` low restarts the count, and the block stays in acquisition.
- R4: A qualified lock moves the block to handover (`mode_o` = 2) for exactly one cycle, with `samp_en`, `subs_en` and `fll_en` all low.
- R5: After handover, the block enters sub-sampling (`mode_o` = 3), with `subs_en` high and `samp_en` low.
- R6: Count the cycles since sub-sampling was entered, starting at 0. In sub-sampling, `fll_en` is high exactly when that count modulo FLL_PERIOD is below FLL_ON. In every other mode `fll_en` is low.
- R7: A dead-zone check is an edge in sub-sampling at which `fll_en` is high. When ODZ_HITS consecutive checks sample `odz_in` high, the block leaves for recovery. A check that samples `odz_in` low restarts the count. Edges at which `fll_en` is low neither count nor restart.
- R8: Recovery (`mode_o` = 4) lasts exactly one cycle with all enables low. It is followed by acquisition, where lock is qualified again from a count of zero.
- R9: `samp_en` and `subs_en` are never high in the same cycle.
- R10: `lock_in` has no effect outside acquisition, and `odz_in` has no effect outside sub-sampling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| lock_in | input | 1 | Lock indication from the sampling loop |
| odz_in | input | 1 | Out-of-dead-zone flag from the auxiliary loop's detector |
| samp_en | output | 1 | Enable for the divider-based sampling loop |
| subs_en | output | 1 | Enable for the divider-less sub-sampling loop |
| fll_en | output | 1 | Duty-cycled enable for the auxiliary frequency loop |
| mode_o | output | 3 | Current mode: 0 reset, 1 acquisition, 2 handover, 3 sub-sampling, 4 recovery |

## Verification
The bench builds the controller with LOCK_CYCLES = 5, FLL_PERIOD = 6, FLL_ON = 2 and ODZ_HITS = 3. These values are small enough to sweep every short lock run from 1 to 4 cycles, and to check the enable window on each cycle across three full auxiliary periods. Because ODZ_HITS is larger than FLL_ON, a run of consecutive dead-zone checks must span an off gap. This shows that off cycles neither count nor clear the run, and that a flag raised during the gap is ignored. The bench also completes a full recovery and relock, with both inputs held high in the modes where they must have no effect.

// File: rtl/lmc_pkg.sv
package lmc_pkg;
  typedef enum logic [2:0] {
    ST_RESET     = 3'd0,
    ST_ACQUIRE   = 3'd1,
    ST_HANDOVER  = 3'd2,
    ST_SUBSAMPLE = 3'd3,
    ST_RECOVER   = 3'd4
  } mode_e;
endpackage

// File: rtl/lmc_run_counter.sv
// Counts consecutive qualifying events; hit pulses on the LIMIT-th one.
module lmc_run_counter #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign hit = inc && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (inc) begin
      cnt <= hit ? '0 : cnt + W'(1);
    end
  end
endmodule

// File: rtl/lmc_duty_timer.sv
// Phase counter that opens a window of ON cycles at the start of every PERIOD.
module lmc_duty_timer #(
  parameter int PERIOD = 32,
  parameter int ON     = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic run_now,
  input  logic run_next,
  output logic win
);
  localparam int PW = $clog2(PERIOD + 1);
  localparam logic [PW-1:0] LASTP = PW'(PERIOD - 1);
  localparam logic [PW-1:0] ONV   = PW'(ON);

  logic [PW-1:0] ph, ph_nxt;

  always_comb begin
    if (run_now && run_next) begin
      ph_nxt = (ph == LASTP) ? '0 : ph + PW'(1);
    end else begin
      ph_nxt = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= '0;
      win <= 1'b0;
    end else begin
      ph  <= ph_nxt;
      win <= run_next && (ph_nxt < ONV);
    end
  end
endmodule

// File: rtl/loop_mode_ctrl.sv
module loop_mode_ctrl
  import lmc_pkg::*;
#(
  parameter int LOCK_CYCLES = 64,
  parameter int FLL_PERIOD  = 32,
  parameter int FLL_ON      = 8,
  parameter int ODZ_HITS    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       lock_in,
  input  logic       odz_in,
  output logic       samp_en,
  output logic       subs_en,
  output logic       fll_en,
  output logic [2:0] mode_o
);
  mode_e st, nxt;
  logic  lock_hit, odz_hit;
  logic  in_acq, in_sub, odz_chk;

  assign in_acq  = (st == ST_ACQUIRE);
  assign in_sub  = (st == ST_SUBSAMPLE);
  assign odz_chk = in_sub && fll_en;

  lmc_run_counter #(.LIMIT(LOCK_CYCLES)) u_lock_q (
    .clk (clk),
    .rst (rst),
    .clr (!in_acq || !lock_in),
    .inc (in_acq && lock_in),
    .hit (lock_hit)
  );

  lmc_run_counter #(.LIMIT(ODZ_HITS)) u_odz_q (
    .clk (clk),
    .rst (rst),
    .clr (!in_sub || (odz_chk && !odz_in)),
    .inc (odz_chk && odz_in),
    .hit (odz_hit)
  );

  always_comb begin
    case (st)
      ST_RESET:     nxt = ST_ACQUIRE;
      ST_ACQUIRE:   nxt = lock_hit ? ST_HANDOVER : ST_ACQUIRE;
      ST_HANDOVER:  nxt = ST_SUBSAMPLE;
      ST_SUBSAMPLE: nxt = odz_hit ? ST_RECOVER : ST_SUBSAMPLE;
      ST_RECOVER:   nxt = ST_ACQUIRE;
      default:      nxt = ST_RESET;
    endcase
  end

  lmc_duty_timer #(.PERIOD(FLL_PERIOD), .ON(FLL_ON)) u_duty (
    .clk      (clk),
    .rst      (rst),
    .run_now  (in_sub),
    .run_next (nxt == ST_SUBSAMPLE),
    .win      (fll_en)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_RESET;
      samp_en <= 1'b0;
      subs_en <= 1'b0;
    end else begin
      st      <= nxt;
      samp_en <= (nxt == ST_ACQUIRE);
      subs_en <= (nxt == ST_SUBSAMPLE);
    end
  end

  assign mode_o = st;
endmodule

// File: rtl/loop_mode_ctrl_chk.sv
module loop_mode_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       lock_in,
  input logic       samp_en,
  input logic       subs_en,
  input logic       fll_en,
  input logic [2:0] mode_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (mode_o == 3'd0 && !samp_en && !subs_en && !fll_en));

  // R2
  start_acquire_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd0) |=> (mode_o == 3'd1 && samp_en));

  // R3
  lock_drop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd1 && !lock_in) |=> (mode_o == 3'd1));

  // R4
  handover_once_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd2) |=> (mode_o == 3'd3 && subs_en && !samp_en));

  // R5
  subs_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(subs_en) |-> ($past(mode_o) == 3'd2));

  // R6
  fll_scope_chk: assert property (@(posedge clk) disable iff (rst)
    fll_en |-> (mode_o == 3'd3));

  // R7
  odz_gap_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd3 && !fll_en) |=> (mode_o == 3'd3));

  // R8
  recover_once_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_o == 3'd4) |=> (mode_o == 3'd1 && samp_en));

  // R9
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(samp_en && subs_en));
endmodule

bind loop_mode_ctrl loop_mode_ctrl_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .lock_in (lock_in),
  .samp_en (samp_en),
  .subs_en (subs_en),
  .fll_en  (fll_en),
  .mode_o  (mode_o)
);

// File: tb/sim_loop_mode_ctrl.sv
`timescale 1ns/1ps
module sim_loop_mode_ctrl;
  localparam int LOCK = 5;
  localparam int PER  = 6;
  localparam int ON   = 2;
  localparam int HITS = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic lock_in = 1'b0;
  logic odz_in = 1'b0;
  logic samp_en, subs_en, fll_en;
  logic [2:0] mode_o;

  int nchk = 0;
  int nfail = 0;
  int overlap_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  loop_mode_ctrl #(
    .LOCK_CYCLES(LOCK), .FLL_PERIOD(PER), .FLL_ON(ON), .ODZ_HITS(HITS)
  ) u0 (
    .clk(clk), .rst(rst), .lock_in(lock_in), .odz_in(odz_in),
    .samp_en(samp_en), .subs_en(subs_en), .fll_en(fll_en), .mode_o(mode_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk_outs(input string req, input int m, input int s, input int u, input int f);
    chk({req, " mode"}, int'(mode_o), m);
    chk({req, " samp_en"}, int'(samp_en), s);
    chk({req, " subs_en"}, int'(subs_en), u);
    chk({req, " fll_en"}, int'(fll_en), f);
  endtask

  always @(negedge clk) begin
    if (!rst && samp_en && subs_en) overlap_bad++;
  end

  initial begin
    int hits;
    int stage;
    int gap;
    bit left;
    tick(); tick(); tick();
    // R1: reset state
    chk_outs("R1", 0, 0, 0, 0);
    rst = 1'b0;
    tick();
    // R2: acquisition after release
    chk_outs("R2", 1, 1, 0, 0);

    // R3: every short lock run, broken by a low cycle, leaves acquisition unchanged
    for (int k = 1; k < LOCK; k++) begin
      lock_in = 1'b1;
      repeat (k) tick();
      lock_in = 1'b0;
      tick();
      chk("R3 short run", int'(mode_o), 1);
    end
    lock_in = 1'b1;
    repeat (LOCK - 1) tick();
    chk("R3 one short of limit", int'(mode_o), 1);
    tick();
    // R4: handover, all off
    chk_outs("R4", 2, 0, 0, 0);
    tick();
    // R5: sub-sampling entered; lock_in still high and ignored (R10)
    chk_outs("R5", 3, 0, 1, 1);

    // R6: duty window over three periods
    for (int i = 0; i < 3 * PER; i++) begin
      chk("R6 window", int'(fll_en), ((i % PER) < ON) ? 1 : 0);
      chk("R10 lock ignored in sub-sampling", int'(mode_o), 3);
      tick();
    end

    // R7: HITS-1 high checks, a flag in the gap, then a low check restarts
    hits = 0; stage = 0; gap = 0;
    while (stage < 3) begin
      if (stage == 0) begin
        if (fll_en) begin
          odz_in = 1'b1; hits++;
          if (hits == HITS - 1) stage = 1;
        end else odz_in = 1'b0;
      end else if (stage == 1) begin
        if (fll_en) begin odz_in = 1'b0; stage = 2; end
        else odz_in = 1'b1;
      end else begin
        odz_in = !fll_en;
        gap++;
        if (gap == 2 * PER) stage = 3;
      end
      tick();
      chk("R7 no exit without full run", int'(mode_o), 3);
    end

    // R7: continuous flag; exit exactly after HITS counted checks
    hits = 0; left = 1'b0;
    for (int i = 0; i < 4 * PER && !left; i++) begin
      odz_in = 1'b1;
      if (fll_en) hits++;
      tick();
      if (hits == HITS) begin
        chk("R7 exit on run", int'(mode_o), 4);
        left = 1'b1;
      end else begin
        chk("R7 stay before run", int'(mode_o), 3);
      end
    end
    chk("R7 exit reached", int'(left), 1);
    // R8: recovery, all off
    chk_outs("R8 recover", 4, 0, 0, 0);
    tick();
    chk_outs("R8 back to acquisition", 1, 1, 0, 0);

    // R8/R10: relock from zero with odz_in held high (ignored)
    repeat (LOCK - 1) tick();
    chk("R10 odz ignored in acquisition", int'(mode_o), 1);
    chk("R6 fll off in acquisition", int'(fll_en), 0);
    tick();
    chk("R8 relock count", int'(mode_o), 2);
    tick();
    chk("R8 sub-sampling again", int'(mode_o), 3);

    // R9: no overlap seen on any cycle
    chk("R9 overlap cycles", overlap_bad, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++;
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end
endmodule